// File: doc/BRIEF.md
# Offset-Aligned Turn Position Unit

This unit sits behind a serial absolute-encoder link master. On each valid strobe it takes the raw single-turn count and the raw multi-turn count. It adds a signed mechanical offset, which software supplies in encoder ticks. The result is a single-turn count that wraps inside one revolution.

In multi-turn mode the revolution counter is realigned. It steps when the corrected single-turn value wraps, not at the encoder's own wrap point. As a result, the two counts always describe the same shifted zero.

The corrected single-turn count is also scaled to a mechanical angle in radians. This uses a truncated fixed-point reciprocal of one revolution. An electrical angle is derived by multiplying the single-turn count by the pole-pair count and keeping only the part inside one revolution. When the single-turn width is too large for the reciprocal to stay nonzero, the angle outputs are flagged invalid.

Top module: `turnpos_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. All result outputs take their new values on that same clock edge, including for strobes on consecutive cycles.
- R2: While `in_valid` is low, every result output keeps its previous value.
- R3: `st_pos` equals (`raw_st` + signed `offset_ticks`) modulo 2^ST_W, in both modes.
- R4: When `multi_turn_en` is 1, `mt_pos` equals `raw_mt` + floor((`raw_st` + `offset_ticks`) / 2^ST_W), modulo 2^MT_W. It therefore moves by +1, 0 or -1 against `raw_mt`, and it wraps through both ends of its range. This holds for an offset with magnitude below 2^ST_W.
- R5: When `multi_turn_en` is 0, `mt_pos` is 0.
- R6: `mech_angle` equals `st_pos` × K, with K = floor(210828714 / 2^ST_W). The value 210828714 is 2π scaled by 2^25, so the angle is in units of 2^-25 rad and never exceeds 2π.
- R7: `elec_angle` equals ((`st_pos` × `pole_pairs`) mod 2^ST_W) × K. A pole-pair count of 0 gives 0.
- R8: `angle_ok` is 1 exactly when K is nonzero, which means ST_W below 28. When it is 0, `mech_angle` and `elec_angle` are 0.
- R9: After reset, `out_valid` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: raw counts are valid this cycle |
| raw_st | input | ST_W | Raw single-turn count |
| raw_mt | input | MT_W | Raw multi-turn count |
| offset_ticks | input | OFS_W | Signed mechanical offset in ticks |
| pole_pairs | input | PP_W | Machine pole-pair count |
| multi_turn_en | input | 1 | 1: realigned revolution counter, 0: single-turn only |
| out_valid | output | 1 | Results updated this cycle |
| st_pos | output | ST_W | Offset-corrected single-turn count |
| mt_pos | output | MT_W | Offset-aligned revolution count |
| mech_angle | output | ANG_W | Mechanical angle, 2^-25 rad units |
| elec_angle | output | ANG_W | Electrical angle, 2^-25 rad units |
| angle_ok | output | 1 | Angle outputs are meaningful |

## Verification
The hardest situation to reach is a revolution step that occurs at the same time as the revolution counter wrapping through its own limits. The stimulus sets `raw_st` a few ticks from either end of the revolution and picks an offset that carries the sum across the boundary. It also sets `raw_mt` to all ones or to zero, so the realigned counter must wrap to 0 or to all ones. The case where the reciprocal quantizes to zero cannot occur at the default width. A second instance with a 28-bit single-turn width covers it.

// File: rtl/turnpos_pkg.sv
package turnpos_pkg;
  // 2*pi scaled by 2^25, truncated
  localparam longint unsigned TWO_PI_Q25 = 64'd210828714;
  localparam int ANG_FRAC = 25;

  // ticks-to-radian scale; truncation makes it zero for wide single-turn fields
  function automatic logic [63:0] recip_for(input int st_w);
    return TWO_PI_Q25 >> st_w;
  endfunction
endpackage

// File: rtl/turnpos_offset.sv
module turnpos_offset #(
  parameter int ST_W  = 25,
  parameter int MT_W  = 12,
  parameter int OFS_W = 32
) (
  input  logic [ST_W-1:0]  raw_st,
  input  logic [MT_W-1:0]  raw_mt,
  input  logic [OFS_W-1:0] offset_ticks,
  input  logic             multi_turn_en,
  output logic [ST_W-1:0]  st_corr,
  output logic [MT_W-1:0]  mt_corr,
  output logic signed [1:0] rev_carry
);
  localparam int SUM_W = ((ST_W > OFS_W) ? ST_W : OFS_W) + 2;

  logic signed [SUM_W-1:0] st_ext;
  logic signed [SUM_W-1:0] ofs_ext;
  logic signed [SUM_W-1:0] sum;

  assign st_ext  = {{(SUM_W-ST_W){1'b0}}, raw_st};
  assign ofs_ext = {{(SUM_W-OFS_W){offset_ticks[OFS_W-1]}}, offset_ticks};
  assign sum     = st_ext + ofs_ext;

  // low bits: wrapped single-turn; arithmetic shift: whole revolutions crossed
  assign st_corr   = sum[ST_W-1:0];
  assign rev_carry = 2'(sum >>> ST_W);

  always_comb begin
    if (multi_turn_en)
      mt_corr = raw_mt + {{(MT_W-2){rev_carry[1]}}, rev_carry};
    else
      mt_corr = '0;
  end
endmodule

// File: rtl/turnpos_scale.sv
module turnpos_scale
  import turnpos_pkg::*;
#(
  parameter int ST_W  = 25,
  parameter int PP_W  = 8,
  parameter int ANG_W = 32
) (
  input  logic [ST_W-1:0]  st_corr,
  input  logic [PP_W-1:0]  pole_pairs,
  output logic [ANG_W-1:0] mech_angle,
  output logic [ANG_W-1:0] elec_angle,
  output logic             angle_ok
);
  localparam logic [ANG_W-1:0] RECIP = ANG_W'(recip_for(ST_W));
  localparam int PROD_W = ST_W + ANG_W;

  logic [ST_W-1:0] elec_turn;

  // fractional revolution of the electrical angle
  assign elec_turn = ST_W'({{PP_W{1'b0}}, st_corr} * {{ST_W{1'b0}}, pole_pairs});

  assign mech_angle = ANG_W'({{ANG_W{1'b0}}, st_corr} * PROD_W'(RECIP));
  assign elec_angle = ANG_W'({{ANG_W{1'b0}}, elec_turn} * PROD_W'(RECIP));
  assign angle_ok   = (RECIP != '0);
endmodule

// File: rtl/turnpos_unit.sv
module turnpos_unit #(
  parameter int ST_W  = 25,
  parameter int MT_W  = 12,
  parameter int OFS_W = 32,
  parameter int PP_W  = 8,
  parameter int ANG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ST_W-1:0]  raw_st,
  input  logic [MT_W-1:0]  raw_mt,
  input  logic [OFS_W-1:0] offset_ticks,
  input  logic [PP_W-1:0]  pole_pairs,
  input  logic             multi_turn_en,
  output logic             out_valid,
  output logic [ST_W-1:0]  st_pos,
  output logic [MT_W-1:0]  mt_pos,
  output logic [ANG_W-1:0] mech_angle,
  output logic [ANG_W-1:0] elec_angle,
  output logic             angle_ok
);
  logic [ST_W-1:0]   st_next;
  logic [MT_W-1:0]   mt_next;
  logic signed [1:0] rev_carry;
  logic [ANG_W-1:0]  mech_next;
  logic [ANG_W-1:0]  elec_next;
  logic              ok_next;

  turnpos_offset #(.ST_W(ST_W), .MT_W(MT_W), .OFS_W(OFS_W)) u_ofs (
    .raw_st        (raw_st),
    .raw_mt        (raw_mt),
    .offset_ticks  (offset_ticks),
    .multi_turn_en (multi_turn_en),
    .st_corr       (st_next),
    .mt_corr       (mt_next),
    .rev_carry     (rev_carry)
  );

  turnpos_scale #(.ST_W(ST_W), .PP_W(PP_W), .ANG_W(ANG_W)) u_scale (
    .st_corr    (st_next),
    .pole_pairs (pole_pairs),
    .mech_angle (mech_next),
    .elec_angle (elec_next),
    .angle_ok   (ok_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      st_pos     <= '0;
      mt_pos     <= '0;
      mech_angle <= '0;
      elec_angle <= '0;
      angle_ok   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        st_pos     <= st_next;
        mt_pos     <= mt_next;
        mech_angle <= mech_next;
        elec_angle <= elec_next;
        angle_ok   <= ok_next;
      end
    end
  end
endmodule

// File: rtl/turnpos_checker.sv
module turnpos_checker
  import turnpos_pkg::*;
#(
  parameter int ST_W  = 25,
  parameter int MT_W  = 12,
  parameter int OFS_W = 32,
  parameter int ANG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [ST_W-1:0]  raw_st,
  input logic [MT_W-1:0]  raw_mt,
  input logic [OFS_W-1:0] offset_ticks,
  input logic             multi_turn_en,
  input logic             out_valid,
  input logic [ST_W-1:0]  st_pos,
  input logic [MT_W-1:0]  mt_pos,
  input logic [ANG_W-1:0] mech_angle,
  input logic [ANG_W-1:0] elec_angle,
  input logic             angle_ok
);
  localparam logic [ANG_W-1:0] TWO_PI = ANG_W'(TWO_PI_Q25);
  localparam logic [MT_W-1:0]  ONE    = MT_W'(1);

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(st_pos) && $stable(mt_pos) &&
                   $stable(mech_angle) && $stable(elec_angle)));

  a_r3_st_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (st_pos == ST_W'($past(raw_st) + $past(offset_ticks))));

  a_r4_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(multi_turn_en)) |->
      ((MT_W'(mt_pos - $past(raw_mt)) == '0) ||
       (MT_W'(mt_pos - $past(raw_mt)) == ONE) ||
       (MT_W'(mt_pos - $past(raw_mt)) == '1)));

  a_r5_single_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(multi_turn_en)) |-> (mt_pos == '0));

  a_r6_angle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((mech_angle <= TWO_PI) && (elec_angle <= TWO_PI)));

  a_r8_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !angle_ok) |-> ((mech_angle == '0) && (elec_angle == '0)));
endmodule

bind turnpos_unit turnpos_checker #(
  .ST_W(ST_W), .MT_W(MT_W), .OFS_W(OFS_W), .ANG_W(ANG_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .raw_st        (raw_st),
  .raw_mt        (raw_mt),
  .offset_ticks  (offset_ticks),
  .multi_turn_en (multi_turn_en),
  .out_valid     (out_valid),
  .st_pos        (st_pos),
  .mt_pos        (mt_pos),
  .mech_angle    (mech_angle),
  .elec_angle    (elec_angle),
  .angle_ok      (angle_ok)
);

// File: tb/test_turnpos_unit.sv
module test_turnpos_unit;
  localparam int ST_W = 25;
  localparam int MT_W = 12;
  localparam longint M  = 64'd1 << ST_W;
  localparam longint MM = 64'd1 << MT_W;
  localparam longint TWO_PI_Q = 64'd210828714;

  typedef struct {
    longint st, mt, mech, elec;
    bit ok;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [ST_W-1:0] raw_st = '0;
  logic [MT_W-1:0] raw_mt = '0;
  logic [31:0] offset_ticks = '0;
  logic [7:0] pole_pairs = '0;
  logic multi_turn_en = 1'b0;
  logic out_valid, angle_ok;
  logic [ST_W-1:0] st_pos;
  logic [MT_W-1:0] mt_pos;
  logic [31:0] mech_angle, elec_angle;

  // second instance: single-turn width where the reciprocal vanishes
  logic w_valid = 1'b0;
  logic [27:0] w_st = '0;
  logic [3:0] w_mt = '0;
  logic w_out_valid, w_ok;
  logic [27:0] w_st_pos;
  logic [3:0] w_mt_pos;
  logic [31:0] w_mech, w_elec;

  int n_cmp = 0;
  int n_bad = 0;
  bit have_last = 0;
  exp_t last;
  exp_t sb[$];

  always #10 clk = ~clk;

  turnpos_unit #(.ST_W(ST_W), .MT_W(MT_W)) i_turnpos_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .raw_st(raw_st),
    .raw_mt(raw_mt), .offset_ticks(offset_ticks), .pole_pairs(pole_pairs),
    .multi_turn_en(multi_turn_en), .out_valid(out_valid), .st_pos(st_pos),
    .mt_pos(mt_pos), .mech_angle(mech_angle), .elec_angle(elec_angle),
    .angle_ok(angle_ok)
  );

  turnpos_unit #(.ST_W(28), .MT_W(4)) i_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(w_valid), .raw_st(w_st),
    .raw_mt(w_mt), .offset_ticks(32'd5), .pole_pairs(8'd3),
    .multi_turn_en(1'b1), .out_valid(w_out_valid), .st_pos(w_st_pos),
    .mt_pos(w_mt_pos), .mech_angle(w_mech), .elec_angle(w_elec),
    .angle_ok(w_ok)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one strobe at the current negedge and push its expected result
  task automatic drive(input longint st, input longint mt, input longint ofs,
                       input longint pp, input bit multi);
    exp_t e;
    longint sum, stc, carry, recip, eturn;
    @(negedge clk);
    raw_st = ST_W'(st);
    raw_mt = MT_W'(mt);
    offset_ticks = 32'(ofs);
    pole_pairs = 8'(pp);
    multi_turn_en = multi;
    in_valid = 1'b1;
    sum = st + ofs;
    stc = ((sum % M) + M) % M;
    carry = (sum - stc) / M;
    recip = TWO_PI_Q >> ST_W;
    eturn = (stc * pp) % M;
    e.st = stc;
    e.mt = multi ? (((mt + carry) % MM) + MM) % MM : 0;
    e.mech = stc * recip;
    e.elec = eturn * recip;
    e.ok = (recip != 0);
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: compare on each result, otherwise check outputs are held
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk("R1", "unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk("R3", "st_pos", longint'(st_pos), e.st);
          chk("R4/R5", "mt_pos", longint'(mt_pos), e.mt);
          chk("R6", "mech_angle", longint'(mech_angle), e.mech);
          chk("R7", "elec_angle", longint'(elec_angle), e.elec);
          chk("R8", "angle_ok", longint'(angle_ok), longint'(e.ok));
          last = e;
          have_last = 1;
        end
      end else if (have_last) begin
        chk("R2", "held st_pos", longint'(st_pos), last.st);
        chk("R2", "held mech_angle", longint'(mech_angle), last.mech);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "out_valid in reset", longint'(out_valid), 0);
    chk("R9", "st_pos in reset", longint'(st_pos), 0);
    chk("R9", "mt_pos in reset", longint'(mt_pos), 0);
    chk("R9", "mech_angle in reset", longint'(mech_angle), 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1", "idle out_valid", longint'(out_valid), 0);

    drive(1000, 5, 0, 2, 1);            idle(3);   // R3 plain
    drive(M - 50, 7, 100, 3, 1);        idle(2);   // R4 forward wrap
    drive(500, 7, -1000, 4, 1);         idle(2);   // R4 backward wrap
    drive(M - 1, MM - 1, 1, 2, 1);      idle(2);   // R4 counter wraps to 0
    drive(0, 0, -1, 2, 1);              idle(2);   // R4 counter wraps to all ones
    drive(M - 10, 9, 20, 2, 0);         idle(2);   // R5 single-turn mode
    drive(M - 1, 3, -(M - 1), 5, 1);    idle(2);   // R3 large negative offset
    drive(M / 2 + 12345, 1, 77, 7, 1);  idle(2);   // R7 electrical wrap
    drive(424242, 2, 3, 0, 1);          idle(2);   // R7 zero pole pairs
    // R1 back-to-back strobes
    drive(10, 1, 0, 1, 1);
    drive(M - 2, 1, 5, 1, 1);
    drive(33, 2, -40, 2, 0);
    idle(4);

    // R8: wide single-turn field, reciprocal is zero
    @(negedge clk);
    w_st = 28'd1000;
    w_mt = 4'd3;
    w_valid = 1'b1;
    @(negedge clk);
    w_valid = 1'b0;
    chk("R8", "wide out_valid", longint'(w_out_valid), 1);
    chk("R8", "wide angle_ok", longint'(w_ok), 0);
    chk("R8", "wide mech_angle", longint'(w_mech), 0);
    chk("R8", "wide elec_angle", longint'(w_elec), 0);
    chk("R3", "wide st_pos", longint'(w_st_pos), 1005);
    chk("R4", "wide mt_pos", longint'(w_mt_pos), 3);
    idle(2);

    chk("R1", "scoreboard drained", longint'(sb.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule